// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is a target on a two-wire serial bus that lets a host read and write a bank of byte-wide configuration registers. The registers live outside the block. The block presents a single register port made of a pointer, a write strobe, write data and combinational read data. SCL and SDA are sampled from a fast system clock through synchronizer flops. START and STOP are recognised as SDA edges while SCL is high. The block answers only to a 7-bit address whose upper four bits are fixed and whose lower three bits come from strap inputs.

In a write, the first byte after the address byte sets the register pointer. Every later byte in that write is stored at the pointer, and the pointer then advances. A read returns bytes starting at the pointer, which advances after each byte. The pointer is kept across STOP, so a host can set it in one transaction and read in a later one. It can also set it and switch direction with a repeated START.

The block also provides an interrupt pin. Its active level is chosen by a configuration input.

Top module: `i2c_cfg_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal binary 1101 followed by strap[2], strap[1], strap[0]. The last bit is the direction: 0 for write, 1 for read. On a mismatch it never pulls SDA low and never writes a register until the next START.
- R2: For an accepted address byte and for every byte written by the host after it, the block pulls SDA low through the ninth SCL clock.
- R3: In a write transaction the first byte after the address loads the pointer. Each later byte produces exactly one `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. Bytes are received MSB first.
- R4: The pointer advances by one after each data byte written or read, and it wraps from 0xFF to 0x00.
- R5: After a read-direction address, the block sends the register at the pointer MSB first, and then the following registers for as long as the host acknowledges. A repeated START after a pointer write starts the read.
- R6: The pointer keeps its value across STOP and a new START. Its value after reset is 0x00.
- R7: After the host answers a read byte with NACK, the block releases SDA and stays silent until a STOP or START.
- R8: SDA is driven open-drain: `sda_out` is always 0, and only `sda_oe` is used to pull the line low.
- R9: `irq_out` equals `irq_src` when `irq_act_high` is 1, and equals the inverse of `irq_src` when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_out | output | 1 | SDA output value, always 0 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| strap | input | 3 | Low three bits of the target address |
| reg_addr | output | 8 | Register pointer |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register contents at `reg_addr` |
| irq_src | input | 1 | Interrupt request, active high |
| irq_act_high | input | 1 | Interrupt polarity select, 1 for active high |
| irq_out | output | 1 | Interrupt pin |

## Verification
If the pointer holds a wrong value, it shows up within one byte. A write pulses `reg_we` with the wrong `reg_addr`, or a read shifts the wrong register out onto SDA. A wrong protocol state shows at the next ninth clock: an acknowledge is missing, an acknowledge appears for a foreign address, or SDA is still pulled low after a NACK. The bench compares every write strobe against a queue of expected writes, and every SDA drive against a window in which the target should be silent. Errors therefore surface in the cycle they reach the pins, not at the end of a transaction.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_RX,
    ST_RACK,
    ST_TX,
    ST_HACK
  } tgt_state_e;

  // address byte upper seven bits against fixed nibble plus straps
  function automatic logic addr_hit(input logic [6:0] rx_addr,
                                    input logic [3:0] fixed_hi,
                                    input logic [2:0] strap);
    return rx_addr == {fixed_hi, strap};
  endfunction

  // pointer step, modulo 256
  function automatic logic [7:0] ptr_advance(input logic [7:0] p);
    return p + 8'd1;
  endfunction

  function automatic logic irq_level(input logic src, input logic act_high);
    return act_high ? src : ~src;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_in;
          sda_pipe <= sda_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_cfg_pkg::*;
#(
  parameter logic [3:0] ADDR_HI = 4'b1101,
  parameter int         BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [2:0]        strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ptr
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  tgt_state_e        st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              ptr_phase, host_ack;

  // named events for assertions and output decode
  logic bus_evt, byte_end, rx_done, host_done;
  assign bus_evt   = start_evt | stop_evt;
  assign byte_end  = scl_fall && (bitcnt == LAST) && !bus_evt;
  assign rx_done   = (st == ST_RX) && byte_end;
  assign host_done = (st == ST_HACK) && scl_fall && !bus_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      bitcnt    <= '0;
      sh        <= '0;
      tx        <= '0;
      ptr       <= '0;
      ptr_phase <= 1'b0;
      host_ack  <= 1'b0;
    end else if (start_evt) begin
      st     <= ST_ADDR;
      bitcnt <= '0;
    end else if (stop_evt) begin
      st <= ST_IDLE;
    end else begin
      unique case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            sh     <= {sh[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            st <= addr_hit(sh[7:1], ADDR_HI, strap) ? ST_AACK : ST_IDLE;
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (sh[0]) begin
              tx <= rd_data;
              st <= ST_TX;
            end else begin
              ptr_phase <= 1'b1;
              st        <= ST_RX;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sh     <= {sh[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            st <= ST_RACK;
            if (ptr_phase) begin
              ptr       <= sh;
              ptr_phase <= 1'b0;
            end else begin
              ptr <= ptr_advance(ptr);
            end
          end
        end
        ST_RACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            st     <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_end) begin
            ptr <= ptr_advance(ptr);
            st  <= ST_HACK;
          end else if (scl_fall) begin
            tx <= {tx[BYTE_W-2:0], 1'b0};
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              tx     <= rd_data;
              bitcnt <= '0;
              st     <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe  = (st == ST_AACK) || (st == ST_RACK) ||
                   ((st == ST_TX) && !tx[BYTE_W-1]);
  assign wr_en   = rx_done && !ptr_phase;
  assign wr_data = sh;

  p_aack_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AACK) |-> addr_hit(sh[7:1], ADDR_HI, strap));

  p_ack_after_rx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> sda_oe);

  p_write_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == ptr_advance($past(ptr))));

  p_start_listens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (st == ST_ADDR) && !sda_oe);

  p_nack_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_done && !host_ack) |=> !sda_oe);

  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> (st == ST_IDLE) && !sda_oe);

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
  import i2c_cfg_pkg::*;
#(
  parameter logic [3:0] ADDR_HI     = 4'b1101,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_out,
  output logic       sda_oe,
  input  logic [2:0] strap,
  output logic [7:0] reg_addr,
  output logic       reg_we,
  output logic [7:0] reg_wdata,
  input  logic [7:0] reg_rdata,
  input  logic       irq_src,
  input  logic       irq_act_high,
  output logic       irq_out
);
  logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  i2c_tgt_fsm #(.ADDR_HI(ADDR_HI), .BYTE_W(8)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .strap     (strap),
    .rd_data   (reg_rdata),
    .sda_oe    (sda_oe),
    .wr_en     (reg_we),
    .wr_data   (reg_wdata),
    .ptr       (reg_addr)
  );

  assign sda_out = 1'b0;
  assign irq_out = irq_level(irq_src, irq_act_high);

  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

endmodule

// File: tb/i2c_cfg_target_test.sv
module i2c_cfg_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic irq_src = 1'b0, irq_act_high = 1'b1;
  logic sda_out, sda_oe, reg_we, irq_out, line;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [7:0] mem_m [256];
  logic [15:0] exp_q[$];
  int ptr_m = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0, silent = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = sda_m & ~sda_oe;

  i2c_cfg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(line),
    .sda_out(sda_out), .sda_oe(sda_oe), .strap(strap),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_src(irq_src), .irq_act_high(irq_act_high),
    .irq_out(irq_out)
  );

  function automatic logic [7:0] seed(input int i);
    return 8'((i * 7) + 3);
  endfunction

  // external register bank
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed(i);
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(irq_out == (irq_act_high ? irq_src : ~irq_src), "R9 irq level",
          int'(irq_out), int'(irq_act_high ? irq_src : ~irq_src));
      if (silent) chk(!sda_oe, "R1/R7 target silent", int'(sda_oe), 0);
      if (reg_we) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected write", {reg_addr, reg_wdata}, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk({reg_addr, reg_wdata} == e, "R3 write addr/data", {reg_addr, reg_wdata}, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4);
    scl_m = 1'b1; tick(8);
    sda_m = 1'b1; tick(8);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(4);
      scl_m = 1'b1; tick(8);
      scl_m = 1'b0; tick(4);
    end
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(4);
    ack = ~line;
    tick(4);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(4);
      scl_m = 1'b1; tick(4);
      b = {b[6:0], line};
      tick(4);
      scl_m = 1'b0; tick(4);
    end
    sda_m = give_ack ? 1'b0 : 1'b1; tick(4);
    scl_m = 1'b1; tick(8);
    scl_m = 1'b0; tick(4);
    sda_m = 1'b1;
  endtask

  // write: address, pointer, data; optional stop
  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input bq_t d,
                        input bit hit, input bit do_stop);
    logic ack;
    if (!hit) silent = 1;
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk(ack == hit, "R1/R2 address ack", int'(ack), int'(hit));
    send_byte(p, ack);
    chk(ack == hit, "R2/R3 pointer ack", int'(ack), int'(hit));
    if (hit) ptr_m = p;
    foreach (d[i]) begin
      if (hit) begin
        exp_q.push_back({8'(ptr_m), d[i]});
        mem_m[ptr_m] = d[i];
        ptr_m = (ptr_m + 1) % 256;
      end
      send_byte(d[i], ack);
      chk(ack == hit, "R2 data ack", int'(ack), int'(hit));
    end
    if (do_stop) bus_stop();
    tick(2);
    chk(exp_q.size() == 0, "R3 writes complete", exp_q.size(), 0);
    silent = 0;
  endtask

  // read n bytes, last one NACKed, then extra clocks to check release
  task automatic rd_txn(input logic [6:0] a, input int n);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({a, 1'b1}, ack);
    chk(ack, "R5 read address ack", int'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      chk(b == mem_m[ptr_m], "R5/R4 read data", b, mem_m[ptr_m]);
      ptr_m = (ptr_m + 1) % 256;
    end
    silent = 1;
    for (int i = 0; i < 2; i++) begin
      tick(4); scl_m = 1'b1; tick(4);
      chk(line == 1'b1, "R7 released after nack", int'(line), 1);
      tick(4); scl_m = 1'b0; tick(4);
    end
    bus_stop();
    tick(2);
    silent = 0;
  endtask

  initial begin
    bq_t d;
    for (int i = 0; i < 256; i++) mem_m[i] = seed(i);
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk(!sda_oe, "R8 reset sda released", int'(sda_oe), 0);
    chk(!reg_we, "R3 reset no write", int'(reg_we), 0);
    chk(reg_addr == 8'h00, "R6 reset pointer", reg_addr, 0);
    chk(sda_out == 1'b0, "R8 open drain value", int'(sda_out), 0);

    // R6: read from reset pointer without setting it
    rd_txn(7'h6D, 2);
    chk(reg_addr == 8'h02, "R4 pointer after read", reg_addr, 2);

    // R3: pointer then three data bytes
    d = '{8'hAA, 8'h55, 8'hC3};
    wr_txn(7'h6D, 8'h10, d, 1, 1);
    chk(reg_addr == 8'h13, "R4 pointer after write", reg_addr, 8'h13);

    // R5: set pointer, repeated start, read back
    d = {};
    wr_txn(7'h6D, 8'h10, d, 1, 0);
    rd_txn(7'h6D, 3);

    // R6: pointer survives stop, new read continues at 0x13
    rd_txn(7'h6D, 1);
    chk(reg_addr == 8'h14, "R6 pointer kept", reg_addr, 8'h14);

    // R1: foreign address (low bit differs) and foreign upper nibble
    d = '{8'h99};
    wr_txn(7'h6C, 8'h00, d, 0, 1);
    wr_txn(7'h5D, 8'h00, d, 0, 1);
    chk(reg_addr == 8'h14, "R1 ignored pointer", reg_addr, 8'h14);
    rd_txn(7'h6D, 1);

    // R4: wrap on writes and on reads
    d = '{8'h11, 8'h22, 8'h33};
    wr_txn(7'h6D, 8'hFE, d, 1, 1);
    chk(reg_addr == 8'h01, "R4 write wrap", reg_addr, 1);
    d = {};
    wr_txn(7'h6D, 8'hFF, d, 1, 0);
    rd_txn(7'h6D, 2);
    chk(reg_addr == 8'h01, "R4 read wrap", reg_addr, 1);

    // R1: new strap value moves the address
    strap = 3'b000;
    tick(4);
    d = '{8'h5A};
    wr_txn(7'h6D, 8'h40, d, 0, 1);
    wr_txn(7'h68, 8'h40, d, 1, 1);
    d = {};
    wr_txn(7'h68, 8'h40, d, 1, 0);
    rd_txn(7'h68, 1);

    // R9: all polarity and source combinations
    for (int k = 0; k < 4; k++) begin
      irq_act_high = k[1];
      irq_src = k[0];
      tick(3);
      chk(irq_out == (k[1] ? k[0] : ~k[0]), "R9 irq combination",
          int'(irq_out), int'(k[1] ? k[0] : ~k[0]));
    end

    tick(10);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule